// File: doc/BRIEF.md
# Channel Power Control and Thermal Shutdown Latch

This block holds the power control word of a multi-channel output converter. The word carries one power-up bit per channel, one bit that chooses how a powered-down output is terminated, and a read-only thermal shutdown flag. The serial front end raises a strobe when a control frame completes and a second strobe when any other write frame completes, such as a converter-code write or a no-operation. A control value is not applied when its own frame arrives. It waits in a shadow register and is committed when the next write frame of either kind completes.

An over-temperature comparator input trips a latch. The latch sets the flag, drives the active-low alarm and forces every channel enable off. The latch holds after the die cools and is released only when a control value is committed. If the comparator is still asserted at that point, the latch trips again on the following cycle. The committed word can be read back at any time.

Two small state machines do the work. The commit machine has the states PEND_IDLE (nothing waiting) and PEND_HELD (a value waiting in the shadow). A control frame moves it to PEND_HELD from either state. Another write frame moves it from PEND_HELD back to PEND_IDLE. Any write frame taken in PEND_HELD commits the shadow. The thermal machine has the states TH_OK and TH_TRIP. It moves from TH_OK to TH_TRIP when the comparator is high and no commit happens in that cycle. It moves from TH_TRIP back to TH_OK on a commit.

Top module: `chan_power_ctl`

## Requirements
- R1: After reset the readback word is 0x40 (termination bit 1, all other bits 0), the alarm output is high and every channel enable is 0.
- R2: Readback bit 0 is the shutdown flag, bit 1 always reads 0, bits 2 to 5 are the power bits of channels 0 to 3 (1 = powered), and bit 6 is the termination bit (1 = tri-state, 0 = resistor to ground). The termination output follows bit 6.
- R3: A control frame alone changes no output. Its value appears in the cycle after the next completed write frame.
- R4: A control frame that arrives while a value is waiting commits the waiting value, and its own value then waits.
- R5: Channel enable i is 1 exactly when power bit i is 1 and no shutdown is latched.
- R6: If the over-temperature input is high at a clock edge with no commit, then from the next cycle the flag reads 1, the alarm is low and every enable is 0.
- R7: The flag and the alarm stay asserted after the over-temperature input falls, for as long as no control value is committed.
- R8: A commit clears the flag whatever bit 0 of the written value holds. Writing 1 to bit 0 never sets the flag.
- R9: If the over-temperature input is still high at the commit that clears the flag, the flag reads 1 again one cycle later.
- R10: The power bits keep their values through a shutdown, and the enables return once the flag clears.
- R11: A write frame that arrives while nothing is waiting changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | One-cycle strobe: a control frame has completed |
| frm_wr_i | input | 1 | One-cycle strobe: another write frame has completed |
| wr_data_i | input | NCH+3 | Control value carried by the control frame |
| over_temp_i | input | 1 | Over-temperature comparator output, active high |
| chan_en_o | output | NCH | Per-channel enable |
| term_tri_o | output | 1 | Termination select (1 = tri-state) |
| alarm_n_o | output | 1 | Alarm, active low |
| rd_data_o | output | NCH+3 | Committed control word for readback |

## Verification
The checker assumes the two frame strobes are never high in the same cycle, because one serial frame ends at a time. The stimulus therefore drives one strobe for a single cycle and then returns it to 0 before the next frame. The checker also treats a cycle in which both strobes are low as a cycle with no commit. The over-temperature input is taken to be synchronous to the clock and may be held high for many cycles. The bench raises it both as a one-cycle pulse and as a long level that is still high when the flag is cleared.

// File: rtl/chan_power_ctl_pkg.sv
package chan_power_ctl_pkg;
    typedef enum logic {PEND_IDLE, PEND_HELD} pend_state_t;
    typedef enum logic {TH_OK, TH_TRIP} therm_state_t;
    localparam int FLAG_BIT = 0;
    localparam int RSV_BIT  = 1;
    localparam int PWR_LSB  = 2;
endpackage

// File: rtl/chan_power_shadow.sv
module chan_power_shadow
    import chan_power_ctl_pkg::*;
#(
    parameter int REG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             frm_wr,
    input  logic [REG_W-1:0] wr_data,
    output logic             commit,
    output logic [REG_W-1:0] commit_val
);
    pend_state_t      state_q, state_d;
    logic [REG_W-1:0] shadow_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: if (ctl_wr) state_d = PEND_HELD;
            PEND_HELD: if (!ctl_wr && frm_wr) state_d = PEND_IDLE;
            default:   state_d = PEND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PEND_IDLE;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            if (ctl_wr) shadow_q <= wr_data;
        end
    end

    always_comb begin
        commit     = (state_q == PEND_HELD) && (ctl_wr || frm_wr);
        commit_val = shadow_q;
    end
endmodule

// File: rtl/chan_power_thermal.sv
module chan_power_thermal
    import chan_power_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic over_temp,
    input  logic clr,
    output logic shut
);
    therm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_OK:   if (over_temp && !clr) state_d = TH_TRIP;
            TH_TRIP: if (clr) state_d = TH_OK;
            default: state_d = TH_OK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        shut = (state_q == TH_TRIP);
    end
endmodule

// File: rtl/chan_power_ctl.sv
module chan_power_ctl
    import chan_power_ctl_pkg::*;
#(
    parameter int  NCH        = 4,
    parameter logic TERM_RST  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  logic             frm_wr_i,
    input  logic [NCH+2:0]   wr_data_i,
    input  logic             over_temp_i,
    output logic [NCH-1:0]   chan_en_o,
    output logic             term_tri_o,
    output logic             alarm_n_o,
    output logic [NCH+2:0]   rd_data_o
);
    localparam int REG_W    = NCH + 3;
    localparam int TERM_BIT = PWR_LSB + NCH;

    logic             commit;
    logic [REG_W-1:0] commit_val;
    logic             shut;
    logic [NCH-1:0]   pwr_q;
    logic             term_q;

    chan_power_shadow #(.REG_W(REG_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr_i),
        .frm_wr     (frm_wr_i),
        .wr_data    (wr_data_i),
        .commit     (commit),
        .commit_val (commit_val)
    );

    chan_power_thermal u_therm (
        .clk       (clk),
        .rst_n     (rst_n),
        .over_temp (over_temp_i),
        .clr       (commit),
        .shut      (shut)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q  <= '0;
            term_q <= TERM_RST;
        end else if (commit) begin
            pwr_q  <= commit_val[PWR_LSB +: NCH];
            term_q <= commit_val[TERM_BIT];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign chan_en_o[i] = pwr_q[i] & ~shut;
    end

    always_comb begin
        rd_data_o                   = '0;
        rd_data_o[FLAG_BIT]         = shut;
        rd_data_o[RSV_BIT]          = 1'b0;
        rd_data_o[PWR_LSB +: NCH]   = pwr_q;
        rd_data_o[TERM_BIT]         = term_q;
        term_tri_o                  = term_q;
        alarm_n_o                   = ~shut;
    end
endmodule

// File: rtl/chan_power_ctl_chk.sv
module chan_power_ctl_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ctl_wr_i,
    input logic           frm_wr_i,
    input logic           over_temp_i,
    input logic [NCH-1:0] chan_en_o,
    input logic           alarm_n_o,
    input logic [NCH+2:0] rd_data_o
);
    // R5
    shut_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_n_o |-> (chan_en_o == '0));

    // R6
    trip_sets_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp_i && !ctl_wr_i && !frm_wr_i) |=> !alarm_n_o);

    // R7
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_n_o && !ctl_wr_i && !frm_wr_i) |=> !alarm_n_o);

    // R2
    flag_matches_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[0] == !alarm_n_o);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[1]);

    // R3
    word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr_i && !frm_wr_i) |=> $stable(rd_data_o[NCH+2:1]));

    // R10
    enable_rise_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|chan_en_o) |-> $past(ctl_wr_i || frm_wr_i));
endmodule

bind chan_power_ctl chan_power_ctl_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_i    (ctl_wr_i),
    .frm_wr_i    (frm_wr_i),
    .over_temp_i (over_temp_i),
    .chan_en_o   (chan_en_o),
    .alarm_n_o   (alarm_n_o),
    .rd_data_o   (rd_data_o)
);

// File: tb/chan_power_ctl_test.sv
`timescale 1ns/1ps
module chan_power_ctl_test;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ctl_wr_i = 1'b0;
    logic           frm_wr_i = 1'b0;
    logic [NCH+2:0] wr_data_i = '0;
    logic           over_temp_i = 1'b0;
    logic [NCH-1:0] chan_en_o;
    logic           term_tri_o;
    logic           alarm_n_o;
    logic [NCH+2:0] rd_data_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // reference model state
    int m_pend = 0, m_sh = 0, m_pwr = 0, m_term = 1, m_flag = 0;

    chan_power_ctl #(.NCH(NCH)) uut (.*);

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 0; m_sh = 0; m_pwr = 0; m_term = 1; m_flag = 0;
        end else begin
            int c;
            c = (m_pend != 0 && (ctl_wr_i || frm_wr_i)) ? 1 : 0;
            if (c != 0) begin
                m_pwr  = (m_sh >> 2) & 15;
                m_term = (m_sh >> 6) & 1;
                m_flag = 0;
            end else if (over_temp_i) begin
                m_flag = 1;
            end
            if (ctl_wr_i) begin
                m_pend = 1; m_sh = int'(wr_data_i);
            end else if (frm_wr_i) begin
                m_pend = 0;
            end
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(rd_data_o), (m_term << 6) | (m_pwr << 2) | m_flag, cur_req, "readback");
            chk(int'(alarm_n_o), m_flag == 0 ? 1 : 0, cur_req, "alarm_n");
            chk(int'(chan_en_o), m_flag != 0 ? 0 : m_pwr, cur_req, "enables");
            chk(int'(term_tri_o), m_term, cur_req, "term");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [NCH+2:0] v);
        @(negedge clk); ctl_wr_i = 1'b1; wr_data_i = v;
        @(negedge clk); ctl_wr_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic frame();
        @(negedge clk); frm_wr_i = 1'b1;
        @(negedge clk); frm_wr_i = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(2);
        cur_req = "R1";
        chk(int'(rd_data_o), 'h40, "R1", "reset word");
        chk(int'(chan_en_o), 0, "R1", "reset enables");
        chk(int'(alarm_n_o), 1, "R1", "reset alarm");

        cur_req = "R3";
        wr_ctl(7'h14);
        idle(3);
        chk(int'(rd_data_o), 'h40, "R3", "unapplied word");
        frame();
        chk(int'(rd_data_o), 'h14, "R3", "applied word");
        chk(int'(chan_en_o), 'h5, "R5", "enables A,C");

        cur_req = "R11";
        frame();
        chk(int'(rd_data_o), 'h14, "R11", "idle frame");

        cur_req = "R2";
        wr_ctl(7'h7C); frame();
        chk(int'(term_tri_o), 1, "R2", "term out");
        chk(int'(chan_en_o), 'hF, "R2", "all channels");

        cur_req = "R4";
        wr_ctl(7'h08); wr_ctl(7'h30);
        chk(int'(rd_data_o), 'h08, "R4", "first value committed");
        frame();
        chk(int'(rd_data_o), 'h30, "R4", "second value committed");

        cur_req = "R8";
        wr_ctl(7'h01); frame();
        chk(int'(rd_data_o), 'h00, "R8", "bit0 write ignored");
        wr_ctl(7'h3C); frame();

        cur_req = "R6";
        @(negedge clk); over_temp_i = 1'b1;
        @(negedge clk); over_temp_i = 1'b0;
        chk(int'(alarm_n_o), 0, "R6", "alarm low");
        chk(int'(chan_en_o), 0, "R6", "enables off");

        cur_req = "R7";
        idle(5);
        chk(int'(alarm_n_o), 0, "R7", "alarm sticky");
        cur_req = "R10";
        chk(int'(rd_data_o), 'h3D, "R10", "power bits held");

        cur_req = "R8";
        wr_ctl(7'h3C); frame();
        chk(int'(alarm_n_o), 1, "R8", "flag cleared");
        cur_req = "R10";
        chk(int'(chan_en_o), 'hF, "R10", "enables back");

        cur_req = "R9";
        @(negedge clk); over_temp_i = 1'b1;
        wr_ctl(7'h3C);
        @(negedge clk); frm_wr_i = 1'b1;
        @(negedge clk); frm_wr_i = 1'b0;
        chk(int'(alarm_n_o), 1, "R9", "cleared one cycle");
        @(negedge clk);
        chk(int'(alarm_n_o), 0, "R9", "retripped");
        over_temp_i = 1'b0;
        wr_ctl(7'h24); frame();
        chk(int'(rd_data_o), 'h24, "R9", "final clear");
        cur_req = "R5";
        chk(int'(chan_en_o), 'h9, "R5", "enables A,D");
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule